// File: doc/BRIEF.md
# Cascaded Interrupt Mask and Latch Controller

This block gathers interrupt sources into two cascaded mask-and-latch stages behind a 32-bit register window. The first stage latches 17 serial-interrupt levels and 7 bus-error events as sticky status bits. Software clears them by writing ones. The status bits are ANDed with a mask, and the result is gated by a global enable to form one summary line.

The second stage takes the summary line as bit 11 of a read-only input register. On every cycle it ORs the masked input into a sticky status register and raises a single registered request while that status is nonzero. A polarity register is kept for software but has no effect on the logic. Offsets that are not implemented read as all-ones and ignore writes. Every access is a full 4-byte word.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: The stage-one control word (0x30), stage-one mask (0x34), stage-two mask (0x54) and polarity word (0x58) store all 32 written bits and read them back unchanged.
- R2: While bit 31 of the control word is 0, the summary line is low, whatever the stage-one status and mask hold, and stage-two status gains no bit.
- R3: With bit 31 of the control word set, the summary line is high exactly when the stage-one status ANDed with the stage-one mask is nonzero.
- R4: A high level on serial input n (0..16) sets stage-one status bit 31-n, read at 0x38. A low level leaves the bit as it was. A set in the same cycle as a clear wins.
- R5: Writing 0x38 clears each status bit written as one and leaves the others. Error event inputs map to status bits as follows: err_evt[0] to bit 2, [1] to bit 3, [2] to bit 4, [3] to bit 5, [4] to bit 6, [5] to bit 7, [6] to bit 10.
- R6: The stage-two input word at 0x5C reads the summary line in bit 11 and zero in every other bit. Writes to it are ignored.
- R7: Stage-two status (0x50) ORs in (input word AND stage-two mask) every cycle. It keeps its bits when the input falls and loses them only through a write of ones to 0x50.
- R8: irq_req is high exactly while stage-two status is nonzero. The polarity word does not change irq_req.
- R9: A read of any offset other than the eight listed ones, including any offset with nonzero low two bits, returns 0xFFFFFFFF. A write there changes no state.
- R10: After reset, every register reads zero and irq_req is low.
- R11: The error-address word at 0x40 reads zero and ignores writes.
- R12: A serial level sampled at clock edge k is readable in stage-one status after edge k. With both stages enabled and unmasked, irq_req rises at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| ser_lvl | input | NUM_SER | Serial-interrupt levels, index n sets status bit 31-n |
| err_evt | input | NUM_ERR | Bus-error event levels |
| irq_req | output | 1 | Registered interrupt request |

## Verification
Every one of the 17 serial inputs and 7 error inputs is pulsed alone. This shows the exact bit each one lands on, that the bit stays after the level drops, and that a write of ones removes only the bits it names. The summary is tried with the enable on and off and with masks that either cover or miss the pending bit, which separates enable gating from mask gating. The second stage is driven through a rise and fall of the summary with its mask set and cleared and with the polarity word at all-ones, so accumulation, stickiness and the inert polarity are each seen at irq_req. A sweep over all 256 byte offsets, read and then written, separates the decoded words from every unmapped or misaligned one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DW = 32;

    // Word offsets decoded by the register window
    localparam logic [7:0] OFF_CTRL  = 8'h30;
    localparam logic [7:0] OFF_MASK1 = 8'h34;
    localparam logic [7:0] OFF_STAT1 = 8'h38;
    localparam logic [7:0] OFF_ERRA  = 8'h40;
    localparam logic [7:0] OFF_STAT2 = 8'h50;
    localparam logic [7:0] OFF_MASK2 = 8'h54;
    localparam logic [7:0] OFF_POL2  = 8'h58;
    localparam logic [7:0] OFF_IN2   = 8'h5C;

    localparam int EN_BIT  = 31;
    localparam int SUM_BIT = 11;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_MASK1,
        SEL_STAT1,
        SEL_ERRA,
        SEL_STAT2,
        SEL_MASK2,
        SEL_POL2,
        SEL_IN2
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] mask1;
        logic [DW-1:0] stat1;
        logic [DW-1:0] mask2;
        logic [DW-1:0] pol2;
        logic [DW-1:0] stat2;
        logic          irq;
    } state_t;

    // Status bit position for error event index i
    function automatic int err_bit_pos(input int i);
        return (i < 6) ? (i + 2) : 10;
    endfunction

endpackage

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFF_CTRL))       sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFF_MASK1)) sel = SEL_MASK1;
        else if (addr == ADDR_W'(OFF_STAT1)) sel = SEL_STAT1;
        else if (addr == ADDR_W'(OFF_ERRA))  sel = SEL_ERRA;
        else if (addr == ADDR_W'(OFF_STAT2)) sel = SEL_STAT2;
        else if (addr == ADDR_W'(OFF_MASK2)) sel = SEL_MASK2;
        else if (addr == ADDR_W'(OFF_POL2))  sel = SEL_POL2;
        else if (addr == ADDR_W'(OFF_IN2))   sel = SEL_IN2;
    end

endmodule

// File: rtl/irqc_src_map.sv
module irqc_src_map
    import irqc_pkg::*;
#(
    parameter int NUM_SER = 17,
    parameter int NUM_ERR = 7
) (
    input  logic [NUM_SER-1:0] ser_lvl,
    input  logic [NUM_ERR-1:0] err_evt,
    output logic [DW-1:0]      set_vec
);

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_SER; i++) begin
            set_vec[DW-1-i] = ser_lvl[i];
        end
        for (int j = 0; j < NUM_ERR; j++) begin
            set_vec[err_bit_pos(j)] = err_evt[j];
        end
    end

endmodule

// File: rtl/irqc_sticky.sv
module irqc_sticky #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] nxt
);

    // A set in the same cycle as a clear keeps the bit
    always_comb nxt = (cur & ~clr) | set;

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_SER = 17,
    parameter int NUM_ERR = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NUM_SER-1:0] ser_lvl,
    input  logic [NUM_ERR-1:0] err_evt,
    output logic              irq_req
);

    state_t        st_d, st_q;
    reg_sel_e      sel;
    logic [DW-1:0] set1, clr1, clr2, set2, in2;
    logic [DW-1:0] stat1_nxt, stat2_nxt;
    logic          summary;
    logic          wr;

    irqc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    irqc_src_map #(.NUM_SER(NUM_SER), .NUM_ERR(NUM_ERR)) u_map (
        .ser_lvl (ser_lvl),
        .err_evt (err_evt),
        .set_vec (set1)
    );

    // Stage one and stage two share the same sticky cell
    irqc_sticky #(.W(DW)) u_lat1 (
        .cur (st_q.stat1),
        .set (set1),
        .clr (clr1),
        .nxt (stat1_nxt)
    );

    irqc_sticky #(.W(DW)) u_lat2 (
        .cur (st_q.stat2),
        .set (set2),
        .clr (clr2),
        .nxt (stat2_nxt)
    );

    assign wr      = bus_sel & bus_we;
    assign clr1    = (wr && sel == SEL_STAT1) ? bus_wdata : '0;
    assign clr2    = (wr && sel == SEL_STAT2) ? bus_wdata : '0;
    assign summary = st_q.ctrl[EN_BIT] & (|(st_q.stat1 & st_q.mask1));
    assign in2     = DW'(summary) << SUM_BIT;
    assign set2    = in2 & st_q.mask2;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (sel)
                SEL_CTRL:  st_d.ctrl  = bus_wdata;
                SEL_MASK1: st_d.mask1 = bus_wdata;
                SEL_MASK2: st_d.mask2 = bus_wdata;
                SEL_POL2:  st_d.pol2  = bus_wdata;
                default:   ;
            endcase
        end
        st_d.stat1 = stat1_nxt;
        st_d.stat2 = stat2_nxt;
        st_d.irq   = |stat2_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_CTRL:  bus_rdata = st_q.ctrl;
            SEL_MASK1: bus_rdata = st_q.mask1;
            SEL_STAT1: bus_rdata = st_q.stat1;
            SEL_ERRA:  bus_rdata = '0;
            SEL_STAT2: bus_rdata = st_q.stat2;
            SEL_MASK2: bus_rdata = st_q.mask2;
            SEL_POL2:  bus_rdata = st_q.pol2;
            SEL_IN2:   bus_rdata = in2;
            default:   bus_rdata = '1;
        endcase
    end

    assign irq_req = st_q.irq;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              ser0,
    input logic              en_bit,
    input logic [31:0]       stat1_q,
    input logic [31:0]       stat2_q,
    input logic              irq_req
);

    logic mapped, wr_stat1;
    assign mapped = (bus_addr == ADDR_W'(8'h30)) || (bus_addr == ADDR_W'(8'h34)) ||
                    (bus_addr == ADDR_W'(8'h38)) || (bus_addr == ADDR_W'(8'h40)) ||
                    (bus_addr == ADDR_W'(8'h50)) || (bus_addr == ADDR_W'(8'h54)) ||
                    (bus_addr == ADDR_W'(8'h58)) || (bus_addr == ADDR_W'(8'h5C));
    assign wr_stat1 = bus_sel && bus_we && (bus_addr == ADDR_W'(8'h38));

    AST_IRQ_TRACKS_STAT2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (stat2_q != 32'h0)) else $error("AST_IRQ_TRACKS_STAT2"); // R8

    AST_SER_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ser0 |=> stat1_q[31]) else $error("AST_SER_LATCHES"); // R4

    AST_STAT1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat1 |=> ((stat1_q & $past(stat1_q)) == $past(stat1_q)))
        else $error("AST_STAT1_STICKY"); // R5

    AST_EN_OFF_NO_STAT2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_bit && stat2_q == 32'h0) |=> stat2_q == 32'h0)
        else $error("AST_EN_OFF_NO_STAT2"); // R2

    AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && !mapped) |-> bus_rdata == 32'hFFFF_FFFF)
        else $error("AST_UNMAPPED_ONES"); // R9

endmodule

bind irq_cascade_ctrl irqc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ser0      (ser_lvl[0]),
    .en_bit    (st_q.ctrl[31]),
    .stat1_q   (st_q.stat1),
    .stat2_q   (st_q.stat2),
    .irq_req   (irq_req)
);

// File: tb/sim_irq_cascade_ctrl.sv
`timescale 1ns/1ps
module sim_irq_cascade_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [16:0] ser_lvl = '0;
    logic [6:0]  err_evt = '0;
    logic        irq_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_cascade_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_lvl(ser_lvl), .err_evt(err_evt), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_ser(input int n);
        @(negedge clk); ser_lvl[n] = 1'b1;
        @(negedge clk); ser_lvl[n] = 1'b0;
    endtask

    function automatic bit is_mapped(input logic [7:0] a);
        return a == 8'h30 || a == 8'h34 || a == 8'h38 || a == 8'h40 ||
               a == 8'h50 || a == 8'h54 || a == 8'h58 || a == 8'h5C;
    endfunction

    function automatic int err_pos(input int j);
        return (j == 6) ? 10 : j + 2;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 / R9: full offset read sweep from reset
        check("R10 irq", {31'h0, irq_req}, 32'h0);
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), v);
            check(is_mapped(8'(a)) ? "R10 reset" : "R9 unmapped read", v,
                  is_mapped(8'(a)) ? 32'h0 : 32'hFFFF_FFFF);
        end

        // R9 / R6 / R11: writes to unmapped and read-only words change nothing
        for (int a = 0; a < 256; a++) begin
            if (!is_mapped(8'(a)) || a == 8'h40 || a == 8'h5C) wr(8'(a), 32'hFFFF_FFFF);
        end
        foreach (v[i]) ;
        rd(8'h30, v); check("R9 ctrl untouched", v, 32'h0);
        rd(8'h34, v); check("R9 mask1 untouched", v, 32'h0);
        rd(8'h54, v); check("R9 mask2 untouched", v, 32'h0);
        rd(8'h58, v); check("R9 pol untouched", v, 32'h0);
        rd(8'h40, v); check("R11 error address", v, 32'h0);
        rd(8'h5C, v); check("R6 input ignores write", v, 32'h0);

        // R1: storage of configuration words
        wr(8'h30, 32'h1234_5678); rd(8'h30, v); check("R1 ctrl", v, 32'h1234_5678);
        wr(8'h34, 32'hA5A5_5A5A); rd(8'h34, v); check("R1 mask1", v, 32'hA5A5_5A5A);
        wr(8'h54, 32'h0F0F_F0F0); rd(8'h54, v); check("R1 mask2", v, 32'h0F0F_F0F0);
        wr(8'h58, 32'hDEAD_BEEF); rd(8'h58, v); check("R1 pol", v, 32'hDEAD_BEEF);
        wr(8'h30, 32'h0); wr(8'h34, 32'h0); wr(8'h54, 32'h0); wr(8'h58, 32'h0);

        // R4 / R5: each serial source lands on bit 31-n, sticks, clears by W1C
        for (int n = 0; n < 17; n++) begin
            pulse_ser(n);
            rd(8'h38, v); check("R4 serial bit", v, 32'h1 << (31 - n));
            wr(8'h38, 32'h1 << (31 - n));
            rd(8'h38, v); check("R5 serial clear", v, 32'h0);
        end

        // R5: error event bit positions
        for (int j = 0; j < 7; j++) begin
            @(negedge clk); err_evt[j] = 1'b1;
            @(negedge clk); err_evt[j] = 1'b0;
            rd(8'h38, v); check("R5 error bit", v, 32'h1 << err_pos(j));
            wr(8'h38, 32'hFFFF_FFFF);
        end

        // R5: partial clear leaves other bits; R4: set wins over clear
        pulse_ser(2); pulse_ser(9);
        wr(8'h38, 32'h1 << 29);
        rd(8'h38, v); check("R5 partial clear", v, 32'h1 << 22);
        @(negedge clk);
        ser_lvl[4] = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h38;
        bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        ser_lvl[4] = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        rd(8'h38, v); check("R4 set wins", v, 32'h1 << 27);
        wr(8'h38, 32'hFFFF_FFFF);

        // R2: enable off gates summary and stage two
        wr(8'h34, 32'hFFFF_FFFF); wr(8'h54, 32'hFFFF_FFFF);
        pulse_ser(5);
        repeat (2) @(negedge clk);
        rd(8'h5C, v); check("R2 summary gated", v, 32'h0);
        rd(8'h50, v); check("R2 stage two idle", v, 32'h0);
        check("R2 irq low", {31'h0, irq_req}, 32'h0);
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h54, 32'h0);

        // R3: summary versus mask coverage for every serial source
        wr(8'h30, 32'h8000_0000);
        for (int n = 0; n < 17; n++) begin
            logic [31:0] m;
            m = (n % 2 == 0) ? (32'h1 << (31 - n)) : (32'h1 << (31 - ((n + 1) % 17)));
            wr(8'h34, m);
            pulse_ser(n);
            rd(8'h5C, v);
            check("R3 summary", v, ((m & (32'h1 << (31 - n))) != 0) ? 32'h800 : 32'h0);
            wr(8'h38, 32'hFFFF_FFFF);
        end

        // R7: mask2 clear keeps stage two empty
        wr(8'h34, 32'hFFFF_FFFF);
        pulse_ser(0);
        repeat (2) @(negedge clk);
        rd(8'h50, v); check("R7 masked off", v, 32'h0);
        wr(8'h38, 32'hFFFF_FFFF);

        // R7 / R8: accumulate, stick, clear
        wr(8'h54, 32'h0000_0800);
        pulse_ser(0);
        repeat (2) @(negedge clk);
        rd(8'h50, v); check("R7 latched", v, 32'h800);
        check("R8 irq high", {31'h0, irq_req}, 32'h1);
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h5C, v); check("R6 summary low", v, 32'h0);
        rd(8'h50, v); check("R7 sticky", v, 32'h800);
        check("R8 irq held", {31'h0, irq_req}, 32'h1);
        wr(8'h50, 32'h800);
        rd(8'h50, v); check("R7 cleared", v, 32'h0);
        check("R8 irq low", {31'h0, irq_req}, 32'h0);

        // R12 with R8: latency, polarity at all ones
        wr(8'h58, 32'hFFFF_FFFF);
        @(negedge clk); ser_lvl[3] = 1'b1;
        @(negedge clk); ser_lvl[3] = 1'b0;
        check("R12 irq after first edge", {31'h0, irq_req}, 32'h0);
        @(negedge clk);
        check("R12 irq after second edge", {31'h0, irq_req}, 32'h1);
        rd(8'h38, v); check("R12 status", v, 32'h1 << 28);
        check("R8 polarity inert", {31'h0, irq_req}, 32'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule